// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps coherence state for a small direct-mapped set of cache lines. It sits on a shared bus that uses write-back and write-invalidate. Each line holds a tag, one data word and one of three states. The states are Invalid, Shared and Modified. Shared means the line is clean, other caches may hold it, and memory is current. Modified means this is the only valid copy and it is dirty.

On the processor side the block takes read, write and replace requests. It answers each one with a bus transaction, or with no transaction when the line state already allows the access. On the snoop side it watches the reads and ownership requests that other caches put on the bus. When it owns a dirty copy that another cache needs, it flushes the data word in place of memory. It then downgrades or drops its own copy.

All outputs are registered and appear one cycle after the inputs that cause them. Arbitration, memory timing and the data path beyond one word per line are handled by the surrounding system.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every line is Invalid, no bus transaction is issued and no flush is signalled. State encoding is I=2'b00, S=2'b01, M=2'b10.
- R2: A processor read (pr_op_i=2'b01) that misses issues BusRd (bus_op_o=2'b01) with the request address. The line then becomes Shared and takes its word from bus_rdata_i. A read that hits in Shared or Modified issues no transaction (bus_op_o=2'b00) and leaves the state unchanged.
- R3: A processor write (pr_op_i=2'b10) to a line that is not Modified issues BusRdX (bus_op_o=2'b10) with the request address. The line then becomes Modified and holds pr_wdata_i. A write that hits in Modified issues no transaction but does update the word.
- R4: A snooped BusRd (snp_op_i=2'b01) that hits a Modified line raises flush_o for one cycle, carrying the line word on flush_data_o. The line becomes Shared.
- R5: A snooped BusRdX (snp_op_i=2'b10) that hits a Shared or Modified line makes it Invalid. When the line was Modified, the line word is flushed first.
- R6: A snooped BusRd that finds the line Shared or Invalid raises no flush and leaves the state unchanged.
- R7: Replacing (pr_op_i=2'b11) a Modified line issues BusWB (bus_op_o=2'b11). The bus carries the line address and word, and the line becomes Invalid. Replacing a Shared line issues nothing and the line becomes Invalid. Replacing a line that is not held does nothing.
- R8: A snooped transaction whose tag differs from the tag of the indexed line has no effect on state, data or flush. So does a snooped BusWB (2'b11).
- R9: When a snoop and a processor request address the same line in the same cycle, the snoop is applied first and the processor request acts on the resulting state.
- R10: A read or write miss on an index whose line is Modified under another tag issues BusWB for that victim, with the victim address and word. The victim becomes Invalid and the request itself is not carried out. A miss over a Shared victim drops it silently and proceeds.
- R11: The address is {tag, index} with the index in the low bits. bus_op_o, bus_addr_o, bus_data_o, flush_o, flush_data_o and pr_state_o all change one clock after the causing inputs. pr_state_o reports the state that the line at pr_addr_i holds after that cycle's updates, and Invalid when the tag differs. bus_addr_o, bus_data_o and flush_data_o are zero when nothing is issued or flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pr_op_i | input | 2 | Processor request: 00 none, 01 read, 10 write, 11 replace |
| pr_addr_i | input | ADDR_W | Processor request address {tag, index} |
| pr_wdata_i | input | DATA_W | Processor write word |
| bus_rdata_i | input | DATA_W | Fill word returned for a BusRd |
| snp_op_i | input | 2 | Snooped transaction, using the bus encoding |
| snp_addr_i | input | ADDR_W | Snooped address {tag, index} |
| bus_op_o | output | 2 | Issued transaction: 00 none, 01 BusRd, 10 BusRdX, 11 BusWB |
| bus_addr_o | output | ADDR_W | Address of the issued transaction |
| bus_data_o | output | DATA_W | Write-back word for BusWB |
| flush_o | output | 1 | One-cycle flush strobe in reply to a snoop |
| flush_data_o | output | DATA_W | Flushed word |
| pr_state_o | output | 2 | Resulting state of the line at pr_addr_i |

## Verification
A directed prologue walks one line through every transition: read miss and hit, write from Shared and from Modified, downgrade and invalidation by snoop, and replacement. It also covers a tag-mismatched snoop, a snoop on an already Shared line, and a snoop and a request to the same line in the same cycle. These separate the snoop rules from the processor rules and show their ordering. The random phase uses a few tags over each index so that hits, conflict victims and snoop matches all occur often. A bench model built from the requirements predicts every output, so a wrong transition, a missing flush or a misplaced write-back address shows up as a mismatch at a known cycle.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10} line_st_e;
  typedef enum logic [1:0] {BUS_NONE = 2'b00, BUS_RD = 2'b01, BUS_RDX = 2'b10, BUS_WB = 2'b11} bus_op_e;
  typedef enum logic [1:0] {PR_NONE = 2'b00, PR_RD = 2'b01, PR_WR = 2'b10, PR_REPL = 2'b11} pr_op_e;
endpackage

// File: rtl/msi_snoop_rule.sv
`timescale 1ns/1ps
module msi_snoop_rule
  import msi_pkg::*;
(
  input  line_st_e st_i,
  input  logic     hit_i,
  input  bus_op_e  op_i,
  output line_st_e st_o,
  output logic     flush_o
);
  always_comb begin
    st_o    = st_i;
    flush_o = 1'b0;
    if (hit_i) begin
      unique case (op_i)
        BUS_RD: if (st_i == ST_M) begin
          st_o    = ST_S;
          flush_o = 1'b1;
        end
        BUS_RDX: begin
          st_o    = ST_I;
          flush_o = (st_i == ST_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_proc_rule.sv
`timescale 1ns/1ps
module msi_proc_rule
  import msi_pkg::*;
(
  input  line_st_e st_i,
  input  logic     hit_i,
  input  pr_op_e   op_i,
  output line_st_e st_o,
  output bus_op_e  bus_o,
  output logic     load_tag_o,
  output logic     load_wdata_o,
  output logic     load_fill_o
);
  logic victim_dirty;
  assign victim_dirty = !hit_i && (st_i == ST_M);

  always_comb begin
    st_o         = st_i;
    bus_o        = BUS_NONE;
    load_tag_o   = 1'b0;
    load_wdata_o = 1'b0;
    load_fill_o  = 1'b0;
    unique case (op_i)
      PR_RD: begin
        if (victim_dirty) begin
          bus_o = BUS_WB;
          st_o  = ST_I;
        end else if (!hit_i) begin
          bus_o       = BUS_RD;
          st_o        = ST_S;
          load_tag_o  = 1'b1;
          load_fill_o = 1'b1;
        end
      end
      PR_WR: begin
        if (victim_dirty) begin
          bus_o = BUS_WB;
          st_o  = ST_I;
        end else begin
          // hit in M is silent; everything else needs ownership
          if (!(hit_i && st_i == ST_M)) bus_o = BUS_RDX;
          st_o         = ST_M;
          load_tag_o   = !hit_i;
          load_wdata_o = 1'b1;
        end
      end
      PR_REPL: begin
        if (hit_i) begin
          if (st_i == ST_M) bus_o = BUS_WB;
          st_o = ST_I;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_line.sv
`timescale 1ns/1ps
module msi_line
  import msi_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_sel_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  bus_op_e           snp_op_i,
  input  logic              pr_sel_i,
  input  pr_op_e            pr_op_i,
  input  logic [TAG_W-1:0]  pr_tag_i,
  input  logic [DATA_W-1:0] pr_wdata_i,
  input  logic [DATA_W-1:0] fill_i,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output bus_op_e           bus_op_o,
  output logic [TAG_W-1:0]  bus_tag_o,
  output logic [DATA_W-1:0] bus_data_o,
  output line_st_e          look_st_o
);
  line_st_e          st_q, mid_st, nxt_st;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;
  logic              snp_hit, pr_hit, load_tag, load_wdata, load_fill;
  pr_op_e            pr_op_eff;

  assign snp_hit   = snp_sel_i && (st_q != ST_I) && (tag_q == snp_tag_i);
  assign pr_op_eff = pr_sel_i ? pr_op_i : PR_NONE;

  msi_snoop_rule u_snoop (
    .st_i   (st_q),
    .hit_i  (snp_hit),
    .op_i   (snp_op_i),
    .st_o   (mid_st),
    .flush_o(flush_o)
  );

  // snoop result feeds the processor rule (R9)
  assign pr_hit = (mid_st != ST_I) && (tag_q == pr_tag_i);

  msi_proc_rule u_proc (
    .st_i        (mid_st),
    .hit_i       (pr_hit),
    .op_i        (pr_op_eff),
    .st_o        (nxt_st),
    .bus_o       (bus_op_o),
    .load_tag_o  (load_tag),
    .load_wdata_o(load_wdata),
    .load_fill_o (load_fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_I;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      st_q <= nxt_st;
      if (load_tag)        tag_q  <= pr_tag_i;
      if (load_wdata)      data_q <= pr_wdata_i;
      else if (load_fill)  data_q <= fill_i;
    end
  end

  assign flush_data_o = flush_o ? data_q : '0;
  assign bus_tag_o    = (bus_op_o == BUS_WB) ? tag_q : pr_tag_i;
  assign bus_data_o   = (bus_op_o == BUS_WB) ? data_q : '0;
  assign look_st_o    = ((load_tag ? pr_tag_i : tag_q) == pr_tag_i) ? nxt_st : ST_I;

  a_r2_read_hit_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_sel_i && pr_op_i == PR_RD && pr_hit && !snp_hit) |=> $stable(st_q));

  a_r3_write_owns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_sel_i && pr_op_i == PR_WR && !(st_q == ST_M && tag_q != pr_tag_i)) |=> (st_q == ST_M));

  a_r4_snoop_rd_downgrades: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_hit && snp_op_i == BUS_RD && st_q == ST_M && !pr_sel_i) |=> (st_q == ST_S));

  a_r5_snoop_rdx_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_hit && snp_op_i == BUS_RDX && !pr_sel_i) |=> (st_q == ST_I));

  a_r8_mismatch_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_sel_i && snp_op_i != BUS_NONE && tag_q != snp_tag_i && !pr_sel_i)
      |=> ($stable(st_q) && $stable(tag_q) && $stable(data_q)));
endmodule

// File: rtl/msi_snoop_ctrl.sv
`timescale 1ns/1ps
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pr_op_i,
  input  logic [ADDR_W-1:0] pr_addr_i,
  input  logic [DATA_W-1:0] pr_wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic [1:0]        pr_state_o
);
  localparam int unsigned LINES = 1 << IDX_W;
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] pr_idx, snp_idx;
  logic [TAG_W-1:0] pr_tag, snp_tag;
  assign pr_idx  = pr_addr_i[IDX_W-1:0];
  assign pr_tag  = pr_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  logic              l_flush [LINES];
  logic [DATA_W-1:0] l_fdata [LINES];
  bus_op_e           l_bus   [LINES];
  logic [TAG_W-1:0]  l_btag  [LINES];
  logic [DATA_W-1:0] l_bdata [LINES];
  line_st_e          l_look  [LINES];
  logic [LINES-1:0]  issue_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    msi_line #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .snp_sel_i   (snp_idx == IDX_W'(g)),
      .snp_tag_i   (snp_tag),
      .snp_op_i    (bus_op_e'(snp_op_i)),
      .pr_sel_i    (pr_idx == IDX_W'(g)),
      .pr_op_i     (pr_op_e'(pr_op_i)),
      .pr_tag_i    (pr_tag),
      .pr_wdata_i  (pr_wdata_i),
      .fill_i      (bus_rdata_i),
      .flush_o     (l_flush[g]),
      .flush_data_o(l_fdata[g]),
      .bus_op_o    (l_bus[g]),
      .bus_tag_o   (l_btag[g]),
      .bus_data_o  (l_bdata[g]),
      .look_st_o   (l_look[g])
    );
    assign issue_vec[g] = (l_bus[g] != BUS_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_op_o     <= BUS_NONE;
      bus_addr_o   <= '0;
      bus_data_o   <= '0;
      flush_o      <= 1'b0;
      flush_data_o <= '0;
      pr_state_o   <= ST_I;
    end else begin
      bus_op_o     <= l_bus[pr_idx];
      bus_addr_o   <= (l_bus[pr_idx] == BUS_NONE) ? '0 : {l_btag[pr_idx], pr_idx};
      bus_data_o   <= l_bdata[pr_idx];
      flush_o      <= l_flush[snp_idx];
      flush_data_o <= l_fdata[snp_idx];
      pr_state_o   <= l_look[pr_idx];
    end
  end

  a_r11_single_issuer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue_vec));

  a_r11_flush_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && $past(snp_op_i) != 2'b01 && $past(snp_op_i) != 2'b10) |-> 1'b0);

  a_r2_read_miss_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_op_o == BUS_RD) |-> (pr_state_o == ST_S));
endmodule

// File: tb/msi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb_top;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;
  localparam int LINES  = 4;

  logic clk = 0;
  logic rst_ni = 0;
  always #2ns clk = ~clk;

  logic [1:0]        pr_op, snp_op;
  logic [ADDR_W-1:0] pr_addr, snp_addr;
  logic [DATA_W-1:0] pr_wdata, bus_rdata;
  logic [1:0]        bus_op, pr_state;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data, flush_data;
  logic              flush;

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .pr_op_i(pr_op), .pr_addr_i(pr_addr), .pr_wdata_i(pr_wdata),
    .bus_rdata_i(bus_rdata), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .bus_op_o(bus_op), .bus_addr_o(bus_addr), .bus_data_o(bus_data),
    .flush_o(flush), .flush_data_o(flush_data), .pr_state_o(pr_state)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [1:0]        m_st  [LINES];
  logic [3:0]        m_tag [LINES];
  logic [DATA_W-1:0] m_dat [LINES];

  logic [1:0]        e_bus, e_st;
  logic [ADDR_W-1:0] e_addr;
  logic [DATA_W-1:0] e_bdata, e_fdata;
  logic              e_flush;
  string             e_tag;
  bit                pending = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(e_tag, "bus_op", bus_op, e_bus);
    check(e_tag, "bus_addr", bus_addr, e_addr);
    check(e_tag, "bus_data", bus_data, e_bdata);
    check(e_tag, "flush", flush, e_flush);
    check(e_tag, "flush_data", flush_data, e_fdata);
    check(e_tag, "pr_state", pr_state, e_st);
  endtask

  function automatic void model(logic [1:0] pop, logic [5:0] pa, logic [DATA_W-1:0] wd,
                                logic [1:0] sop, logic [5:0] sa, logic [DATA_W-1:0] fill);
    int si = sa[1:0];
    int pi = pa[1:0];
    logic [3:0] stg = sa[5:2];
    logic [3:0] ptg = pa[5:2];
    bit hit;
    e_bus = 2'b00; e_addr = '0; e_bdata = '0; e_flush = 0; e_fdata = '0;
    e_tag = "R11";
    // snoop first (R9)
    if ((sop == 2'b01 || sop == 2'b10) && m_st[si] != 2'b00 && m_tag[si] == stg) begin
      if (sop == 2'b01 && m_st[si] == 2'b10) begin
        e_flush = 1; e_fdata = m_dat[si]; m_st[si] = 2'b01; e_tag = "R4";
      end else if (sop == 2'b10) begin
        if (m_st[si] == 2'b10) begin e_flush = 1; e_fdata = m_dat[si]; end
        m_st[si] = 2'b00; e_tag = "R5";
      end else e_tag = "R6";
    end else if (sop != 2'b00) e_tag = "R8";
    hit = (m_st[pi] != 2'b00) && (m_tag[pi] == ptg);
    case (pop)
      2'b01: begin
        if (!hit && m_st[pi] == 2'b10) begin
          e_bus = 2'b11; e_addr = {m_tag[pi], pa[1:0]}; e_bdata = m_dat[pi];
          m_st[pi] = 2'b00; e_tag = "R10";
        end else if (!hit) begin
          e_bus = 2'b01; e_addr = pa; m_st[pi] = 2'b01; m_tag[pi] = ptg; m_dat[pi] = fill;
          e_tag = "R2";
        end else e_tag = "R2";
      end
      2'b10: begin
        if (!hit && m_st[pi] == 2'b10) begin
          e_bus = 2'b11; e_addr = {m_tag[pi], pa[1:0]}; e_bdata = m_dat[pi];
          m_st[pi] = 2'b00; e_tag = "R10";
        end else begin
          if (!(hit && m_st[pi] == 2'b10)) begin e_bus = 2'b10; e_addr = pa; end
          m_st[pi] = 2'b10; m_tag[pi] = ptg; m_dat[pi] = wd; e_tag = "R3";
        end
      end
      2'b11: begin
        if (hit) begin
          if (m_st[pi] == 2'b10) begin
            e_bus = 2'b11; e_addr = {m_tag[pi], pa[1:0]}; e_bdata = m_dat[pi];
          end
          m_st[pi] = 2'b00;
        end
        e_tag = "R7";
      end
      default: ;
    endcase
    if (pop != 2'b00 && sop != 2'b00 && si == pi) e_tag = "R9";
    e_st = (m_st[pi] != 2'b00 && m_tag[pi] == ptg) ? m_st[pi] : 2'b00;
  endfunction

  task automatic step(logic [1:0] pop, logic [5:0] pa, logic [DATA_W-1:0] wd,
                      logic [1:0] sop, logic [5:0] sa, logic [DATA_W-1:0] fill);
    @(negedge clk);
    if (pending) compare();
    pr_op = pop; pr_addr = pa; pr_wdata = wd; snp_op = sop; snp_addr = sa; bus_rdata = fill;
    model(pop, pa, wd, sop, sa, fill);
    pending = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pr_op = 0; pr_addr = 0; pr_wdata = 0; snp_op = 0; snp_addr = 0; bus_rdata = 0;
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "bus_op in reset", bus_op, 0);
    check("R1", "flush in reset", flush, 0);
    check("R1", "pr_state in reset", pr_state, 0);
    rst_ni = 1;
    // R1: every line Invalid after reset
    for (int i = 0; i < LINES; i++) step(2'b00, 6'(i + 4), 0, 2'b00, 0, 0);
    // directed walk
    step(2'b01, 6'h04, 0, 0, 0, 16'h1111);      // R2 read miss
    step(2'b01, 6'h04, 0, 0, 0, 16'h2222);      // R2 read hit in S
    step(2'b10, 6'h04, 16'hA0A0, 0, 0, 0);      // R3 write from S
    step(2'b10, 6'h04, 16'hA1A1, 0, 0, 0);      // R3 write hit M
    step(2'b01, 6'h04, 0, 0, 0, 0);             // R2 read hit in M
    step(2'b00, 6'h04, 0, 2'b01, 6'h08, 0);     // R8 tag mismatch
    step(2'b00, 6'h04, 0, 2'b11, 6'h04, 0);     // R8 snooped BusWB
    step(2'b00, 6'h04, 0, 2'b01, 6'h04, 0);     // R4 downgrade, flush A1A1
    step(2'b00, 6'h04, 0, 2'b01, 6'h04, 0);     // R6 snoop on Shared
    step(2'b00, 6'h04, 0, 2'b10, 6'h04, 0);     // R5 Shared dropped, no flush
    step(2'b00, 6'h04, 0, 2'b01, 6'h04, 0);     // R6 snoop on Invalid
    step(2'b10, 6'h04, 16'hB0B0, 0, 0, 0);
    step(2'b00, 6'h04, 0, 2'b10, 6'h04, 0);     // R5 Modified flushed
    step(2'b10, 6'h05, 16'hC0C0, 0, 0, 0);
    step(2'b01, 6'h05, 0, 2'b10, 6'h05, 16'h3333); // R9 snoop first, then miss
    step(2'b10, 6'h06, 16'hD0D0, 0, 0, 0);
    step(2'b01, 6'h0A, 0, 0, 0, 16'h4444);      // R10 dirty victim
    step(2'b01, 6'h0A, 0, 0, 0, 16'h4444);      // R2 now a miss
    step(2'b10, 6'h0E, 16'hE0E0, 0, 0, 0);      // R10 Shared victim dropped
    step(2'b11, 6'h0E, 0, 0, 0, 0);             // R7 replace M
    step(2'b01, 6'h07, 0, 0, 0, 16'h5555);
    step(2'b11, 6'h07, 0, 0, 0, 0);             // R7 replace S
    step(2'b11, 6'h07, 0, 0, 0, 0);             // R7 replace not held
    // random phase
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] pa = {2'b00, 2'($urandom), 2'($urandom)};
      logic [5:0] sa = {2'b00, 2'($urandom), 2'($urandom)};
      step(2'($urandom), pa, 16'($urandom), 2'($urandom), sa, 16'($urandom));
    end
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule